// File: doc/BRIEF.md
# FIFO Watermark Burst Request Generator

This block sits beside the transmit and receive FIFOs of a serial peripheral and turns their fill levels into burst requests for a DMA controller. The transmit channel asks for a refill once the transmit FIFO has drained to its programmed low mark. The receive channel asks for an unload once the receive FIFO holds more entries than its programmed high mark. Each request covers one burst of a programmed number of items.

Once the DMA controller accepts a request, the channel holds the request line high. It counts item strobes until the whole burst has moved, then drops the line for at least one cycle. This stops a stale FIFO level from starting a second burst too early. Each direction has its own enable. A peripheral-wide enable gates both channels and cancels any burst in flight. For a 32-entry transmit FIFO, the transmit low mark would normally be set to 32 minus the burst size. The receive high mark would normally be set to the burst size minus one.

Top module: `dma_wm_req`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, both `tx_req` and `rx_req` are low.
- R2: With both enables high and the TX channel idle, `tx_req` goes high one clock edge after `tx_level <= tx_wmark` is sampled. It stays low while `tx_level > tx_wmark`.
- R3: With both enables high and the RX channel idle, `rx_req` goes high one edge after `rx_level >= rx_wmark + 1` is sampled. The compare is done without wraparound, so a high mark at the all-ones value never requests.
- R4: A raised request stays high until the DMA controller accepts it (`*_ack` high), and through the burst that follows. It goes low in the cycle after the edge that samples the burst's final `*_strobe`.
- R5: Strobes that arrive before a request is accepted are not counted toward the burst.
- R6: A burst length of 0 or 1 ends the burst at its first strobe.
- R7: After a burst ends, the request is low for exactly one cycle. If the threshold still holds in that cycle, the request rises again at the next edge.
- R8: Dropping a direction enable forces that request low in the same cycle and cancels its burst. After re-enabling, the channel starts again from idle.
- R9: Dropping `periph_en` forces both requests low in the same cycle and returns both channels to idle.
- R10: The TX and RX channels are independent: strobes, acks and levels of one channel never change the other channel's request.
- R11: The burst length is captured when the request is accepted. Changing `burst_len` during a burst does not change that burst's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; low forces both requests low |
| tx_dma_en | input | 1 | Enables the TX request channel |
| rx_dma_en | input | 1 | Enables the RX request channel |
| tx_level | input | LVL_W (6) | TX FIFO occupancy |
| rx_level | input | LVL_W (6) | RX FIFO occupancy |
| tx_wmark | input | LVL_W (6) | TX low mark |
| rx_wmark | input | LVL_W (6) | RX high mark |
| burst_len | input | LVL_W (6) | Items per burst (0 treated as 1) |
| tx_ack | input | 1 | DMA controller accepts the TX request |
| tx_strobe | input | 1 | One TX item moved |
| rx_ack | input | 1 | DMA controller accepts the RX request |
| rx_strobe | input | 1 | One RX item moved |
| tx_req | output | 1 | TX burst request |
| rx_req | output | 1 | RX burst request |

## Verification
The channel state is updated at each clock edge, and the enable gate on each request is combinational. A threshold, ack or strobe therefore shows up on the request one edge later. An enable drop shows up in the same cycle. The bench changes inputs on the falling edge. It advances its reference model at the rising edge that samples those inputs, and compares both request lines at the next falling edge. For enable-drop cases it adds a check shortly after the input changes, before any edge.

// File: rtl/wm_dma_pkg.sv
// Package: shared types for the watermark request channels.
// Assumes: nothing beyond standard SystemVerilog.
package wm_dma_pkg;

    // Per-channel request state.
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,   // watching the threshold
        CH_PEND  = 2'd1,   // request raised, waiting for acceptance
        CH_BURST = 2'd2    // accepted, counting item strobes
    } ch_state_e;

    // Channel index for the generate loop in the top.
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int NUM_DIR = 2;

endpackage

// File: rtl/wm_level_cmp.sv
// Module: threshold compare for one FIFO direction.
// IS_RX = 0: hit when level <= mark (drain side).
// IS_RX = 1: hit when level >= mark + 1, computed one bit wider so it cannot wrap.
// Assumes: level and mark share the same width.
module wm_level_cmp #(
    parameter int LVL_W = 6,
    parameter bit IS_RX = 1'b0
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] mark_i,
    output logic             hit_o
);

    localparam int EXT_W = LVL_W + 1;

    generate
        if (IS_RX) begin : g_rx
            logic [EXT_W-1:0] lvl_ext;
            logic [EXT_W-1:0] mark_plus;
            // Widen both operands so mark + 1 never overflows.
            always_comb begin
                lvl_ext   = {1'b0, level_i};
                mark_plus = {1'b0, mark_i} + EXT_W'(1);
                hit_o     = (lvl_ext >= mark_plus);
            end
        end else begin : g_tx
            // The drain side requests at or below its mark.
            always_comb hit_o = (level_i <= mark_i);
        end
    endgenerate

endmodule

// File: rtl/wm_beat_cnt.sv
// Module: counts the item strobes of one accepted burst.
// On load it captures the burst length and clears the count. last_o pulses on
// the strobe that completes the burst. A length of 0 is treated as 1.
// Assumes: load_i and active_i are never both high.
module wm_beat_cnt #(
    parameter int BURST_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [BURST_W-1:0] len_i,
    input  logic               active_i,
    input  logic               beat_i,
    output logic               last_o
);

    localparam int EXT_W = BURST_W + 1;

    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] len_q;
    logic [BURST_W-1:0] eff_len;
    logic [EXT_W-1:0]   cnt_next;

    // Effective length and the count after this strobe.
    always_comb begin
        eff_len  = (len_q == '0) ? BURST_W'(1) : len_q;
        cnt_next = {1'b0, cnt_q} + EXT_W'(1);
        last_o   = active_i && beat_i && (cnt_next >= {1'b0, eff_len});
    end

    // Capture the length on load; count strobes while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            len_q <= len_i;
        end else if (active_i && beat_i) begin
            cnt_q <= last_o ? '0 : cnt_q + BURST_W'(1);
        end
    end

    // R4: inside a burst the count stays below the captured length.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (cnt_q < eff_len));

    // R11: the captured length holds for the whole burst.
    assert_len_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !load_i) |=> (!$past(active_i) || $stable(len_q) || $past(load_i)));

endmodule

// File: rtl/wm_req_fsm.sv
// Module: one request channel. It combines the threshold compare, the state
// machine and the strobe counter.
// IDLE -> PEND on a threshold hit. PEND -> BURST on acceptance.
// BURST -> IDLE on the final strobe. A low enable returns to IDLE.
// Assumes: ack and strobe are synchronous to clk.
module wm_req_fsm
    import wm_dma_pkg::*;
#(
    parameter int LVL_W   = 6,
    parameter int BURST_W = 6,
    parameter bit IS_RX   = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [LVL_W-1:0]   level_i,
    input  logic [LVL_W-1:0]   mark_i,
    input  logic [BURST_W-1:0] len_i,
    input  logic               ack_i,
    input  logic               beat_i,
    output logic               req_o
);

    ch_state_e state_q;
    ch_state_e state_d;
    logic      hit_w;
    logic      last_w;
    logic      load_w;
    logic      active_w;

    wm_level_cmp #(
        .LVL_W (LVL_W),
        .IS_RX (IS_RX)
    ) u_cmp (
        .level_i (level_i),
        .mark_i  (mark_i),
        .hit_o   (hit_w)
    );

    // Burst bookkeeping: load on acceptance, count while in BURST.
    always_comb begin
        load_w   = (state_q == CH_PEND) && ack_i && en_i;
        active_w = (state_q == CH_BURST) && en_i;
    end

    wm_beat_cnt #(
        .BURST_W (BURST_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .len_i    (len_i),
        .active_i (active_w),
        .beat_i   (beat_i),
        .last_o   (last_w)
    );

    // Next-state selection for the request channel.
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = CH_IDLE;
        end else begin
            case (state_q)
                CH_IDLE:  if (hit_w)  state_d = CH_PEND;
                CH_PEND:  if (ack_i)  state_d = CH_BURST;
                CH_BURST: if (last_w) state_d = CH_IDLE;
                default:              state_d = CH_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Request output: raised in PEND and BURST, gated by the enable.
    always_comb req_o = (state_q != CH_IDLE) && en_i;

    // R2 (R3 for the receive instance): a rising request follows a threshold hit.
    assert_rise_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(hit_w));

    // R4: the request holds until the final strobe while enabled.
    assert_hold_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !last_w) |=> (req_o || !en_i));

    // R7: the final strobe is followed by a low request.
    assert_gap_after_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_w |=> !req_o);

    // R8: a low enable returns the channel to idle.
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == CH_IDLE));

endmodule

// File: rtl/dma_wm_req.sv
// Module: top of the watermark burst request generator. It holds two channels,
// one for the drain-side (TX) FIFO and one for the fill-side (RX) FIFO.
// Assumes: FIFO levels are registered by the FIFOs in the same clock domain.
module dma_wm_req
    import wm_dma_pkg::*;
#(
    parameter int TX_DEPTH = 32,
    parameter int RX_DEPTH = 32,
    parameter int LVL_W    = $clog2(((TX_DEPTH > RX_DEPTH) ? TX_DEPTH : RX_DEPTH) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_wmark,
    input  logic [LVL_W-1:0] rx_wmark,
    input  logic [LVL_W-1:0] burst_len,
    input  logic             tx_ack,
    input  logic             tx_strobe,
    input  logic             rx_ack,
    input  logic             rx_strobe,
    output logic             tx_req,
    output logic             rx_req
);

    localparam int BURST_W = LVL_W;

    logic             en_a    [NUM_DIR];
    logic [LVL_W-1:0] lvl_a   [NUM_DIR];
    logic [LVL_W-1:0] mark_a  [NUM_DIR];
    logic             ack_a   [NUM_DIR];
    logic             beat_a  [NUM_DIR];
    logic             req_a   [NUM_DIR];

    // Collect per-direction inputs into arrays for the channel loop.
    always_comb begin
        en_a[DIR_TX]   = periph_en && tx_dma_en;
        en_a[DIR_RX]   = periph_en && rx_dma_en;
        lvl_a[DIR_TX]  = tx_level;
        lvl_a[DIR_RX]  = rx_level;
        mark_a[DIR_TX] = tx_wmark;
        mark_a[DIR_RX] = rx_wmark;
        ack_a[DIR_TX]  = tx_ack;
        ack_a[DIR_RX]  = rx_ack;
        beat_a[DIR_TX] = tx_strobe;
        beat_a[DIR_RX] = rx_strobe;
    end

    generate
        for (genvar d = 0; d < NUM_DIR; d++) begin : g_ch
            wm_req_fsm #(
                .LVL_W   (LVL_W),
                .BURST_W (BURST_W),
                .IS_RX   (d == DIR_RX)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (en_a[d]),
                .level_i (lvl_a[d]),
                .mark_i  (mark_a[d]),
                .len_i   (burst_len),
                .ack_i   (ack_a[d]),
                .beat_i  (beat_a[d]),
                .req_o   (req_a[d])
            );
        end
    endgenerate

    // Drive the request ports from the channel outputs.
    always_comb begin
        tx_req = req_a[DIR_TX];
        rx_req = req_a[DIR_RX];
    end

    // R9: after a cycle with the peripheral disabled, both channels restart from idle.
    assert_periph_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (!tx_req && !rx_req));

    // R1: the first cycle after reset shows no request.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_req && !rx_req));

endmodule

// File: tb/dma_wm_req_tb.sv
`timescale 1ns/1ps
module dma_wm_req_tb;

    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          periph_en = 1'b0, tx_dma_en = 1'b0, rx_dma_en = 1'b0;
    logic [LW-1:0] tx_level = '0, rx_level = '0, tx_wmark = '0, rx_wmark = '0, burst_len = '0;
    logic          tx_ack = 1'b0, tx_strobe = 1'b0, rx_ack = 1'b0, rx_strobe = 1'b0;
    logic          tx_req, rx_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state per direction (0 idle, 1 pending, 2 burst).
    int mst [2];
    int mcnt[2];
    int mlen[2];

    always #4 clk = ~clk;

    dma_wm_req u_dut (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_wmark(tx_wmark), .rx_wmark(rx_wmark), .burst_len(burst_len),
        .tx_ack(tx_ack), .tx_strobe(tx_strobe),
        .rx_ack(rx_ack), .rx_strobe(rx_strobe),
        .tx_req(tx_req), .rx_req(rx_req)
    );

    function automatic bit hit_of(int d);
        if (d == 0) return int'(tx_level) <= int'(tx_wmark);
        return int'(rx_level) >= int'(rx_wmark) + 1;
    endfunction

    function automatic bit en_of(int d);
        return periph_en && ((d == 0) ? tx_dma_en : rx_dma_en);
    endfunction

    function automatic bit exp_req(int d);
        return (mst[d] != 0) && en_of(d);
    endfunction

    task automatic expect_bit(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance the model at the rising edge that samples the current inputs.
    task automatic model_step();
        for (int d = 0; d < 2; d++) begin
            bit ack = (d == 0) ? tx_ack : rx_ack;
            bit stb = (d == 0) ? tx_strobe : rx_strobe;
            if (!rst_n || !en_of(d)) begin
                mst[d] = 0;
            end else if (mst[d] == 0) begin
                if (hit_of(d)) mst[d] = 1;
            end else if (mst[d] == 1) begin
                if (ack) begin mst[d] = 2; mcnt[d] = 0; mlen[d] = int'(burst_len); end
            end else if (stb) begin
                int eff = (mlen[d] == 0) ? 1 : mlen[d];
                if (mcnt[d] + 1 >= eff) mst[d] = 0;
                else mcnt[d]++;
            end
        end
    endtask

    // One clock: step the model, then compare both requests at the falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        expect_bit(tx_req, exp_req(0), {tag, " tx"});
        expect_bit(rx_req, exp_req(1), {tag, " rx"});
    endtask

    task automatic quiet();
        tx_ack = 0; rx_ack = 0; tx_strobe = 0; rx_strobe = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int d = 0; d < 2; d++) begin mst[d] = 0; mcnt[d] = 0; mlen[d] = 0; end
        // R1: reset holds requests low even with thresholds met and enables high.
        @(negedge clk);
        periph_en = 1; tx_dma_en = 1; rx_dma_en = 1;
        tx_level = 0; tx_wmark = 10; rx_level = 20; rx_wmark = 3; burst_len = 4;
        tick("R1 reset"); tick("R1 reset");
        expect_bit(tx_req, 1'b0, "R1 tx in reset");
        rst_n = 1;
        #1 expect_bit(rx_req, 1'b0, "R1 rx first cycle after reset");
        @(negedge clk);
        periph_en = 0; tick("R1 settle");
        periph_en = 1;
        // R2: drain side, above the mark then at the mark.
        rx_level = 0; tx_wmark = 16; tx_level = 17;
        tick("R2 above mark"); tick("R2 above mark");
        expect_bit(tx_req, 1'b0, "R2 level above mark");
        tx_level = 16; tick("R2 at mark");
        expect_bit(tx_req, 1'b1, "R2 level at mark");
        tx_dma_en = 0; tick("R8 off");
        tx_dma_en = 1; tx_level = 30;
        // R3: fill side, at the mark then one above it; all-ones mark.
        rx_wmark = 8; rx_level = 8; tick("R3 at mark");
        expect_bit(rx_req, 1'b0, "R3 level equals mark");
        rx_level = 9; tick("R3 above mark");
        expect_bit(rx_req, 1'b1, "R3 level mark+1");
        rx_dma_en = 0; tick("R8 rx off");
        rx_dma_en = 1; rx_wmark = 6'h3f; rx_level = 6'h3f;
        tick("R3 max mark"); tick("R3 max mark");
        expect_bit(rx_req, 1'b0, "R3 all-ones mark never requests");
        // R5 and R4: early strobes ignored, then a full burst of 4.
        rx_wmark = 3; rx_level = 20; tick("R4 raise");
        rx_strobe = 1; tick("R5 early"); tick("R5 early"); tick("R5 early");
        rx_strobe = 0; rx_ack = 1; burst_len = 4; tick("R4 accept");
        rx_ack = 0; burst_len = 1; rx_strobe = 1;     // R11: length changed mid-burst
        tick("R4 beat1"); tick("R4 beat2"); tick("R4 beat3");
        expect_bit(rx_req, 1'b1, "R5/R11 still high after 3 of 4 strobes");
        tick("R4 beat4");
        expect_bit(rx_req, 1'b0, "R4 low after final strobe");
        rx_strobe = 0; tick("R7 re-raise");
        expect_bit(rx_req, 1'b1, "R7 re-raised after one-cycle gap");
        // R6: zero-length burst ends on first strobe.
        burst_len = 0; rx_ack = 1; tick("R6 accept");
        rx_ack = 0; rx_strobe = 1; tick("R6 beat");
        expect_bit(rx_req, 1'b0, "R6 length 0 ends after one strobe");
        rx_strobe = 0; rx_level = 0; tick("R6 idle");
        // R8: enable drop in the middle of a burst drops at once and restarts.
        tx_level = 2; tx_wmark = 4; burst_len = 3; tick("R8 raise");
        tx_ack = 1; tick("R8 accept");
        tx_ack = 0; tx_strobe = 1; tick("R8 beat");
        tx_dma_en = 0;
        #1 expect_bit(tx_req, 1'b0, "R8 same-cycle drop");
        tick("R8 off"); tx_strobe = 0; tx_dma_en = 1; tick("R8 re-raise");
        // R9: peripheral disable drops both requests in the same cycle.
        rx_level = 20; tick("R9 rx raise");
        periph_en = 0;
        #1 expect_bit(tx_req | rx_req, 1'b0, "R9 both low same cycle");
        tick("R9 off");
        periph_en = 1; tick("R9 back");
        // R10: random mix across both channels against the model.
        for (int i = 0; i < 4000; i++) begin
            periph_en = ($urandom % 64) != 0;
            tx_dma_en = ($urandom % 32) != 0;
            rx_dma_en = ($urandom % 32) != 0;
            tx_level  = LW'($urandom % 33);
            rx_level  = LW'($urandom % 33);
            if (($urandom % 8) == 0) begin
                tx_wmark = LW'($urandom % 33);
                rx_wmark = LW'($urandom % 33);
            end
            burst_len = LW'($urandom % 9);
            tx_ack    = ($urandom % 4) == 0;
            rx_ack    = ($urandom % 4) == 0;
            tx_strobe = ($urandom % 2) == 0;
            rx_strobe = ($urandom % 2) == 0;
            tick("R10 random");
        end
        quiet();
        tick("R10 end");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule